// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame is for this node. It looks only at the frame's destination address, which arrives as six bytes, one per `byte_valid` beat. While the bytes stream in, it builds a CRC-32 over them. From the low bits of that CRC it forms a 6-bit hash index. The index selects one bit of a 64-bit group table, which is held as a high and a low 32-bit register.

The path depends on the address type:
- **Group addresses** (multicast) are accepted when the selected table bit is set.
- **Individual addresses** are accepted only when they match the programmed 48-bit station address exactly.
- **Promiscuous mode** accepts everything.

One cycle after the sixth byte, the block raises a single-cycle verdict strobe together with the accept flag. It also publishes the hash index it used, for debug. Software programs the table and the station address through a small write port with a 2-bit register select.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset `decision_valid`, `accept` and `hash_index` are 0, and both group-table registers are 0, so a group address with `promisc_en` low is rejected.
- R2: The CRC is reloaded to all ones at the first byte. Each byte is consumed least significant bit first. At each bit, the register shifts left and is XORed with 0x04C11DB7 when its old MSB differs from the data bit. No final inversion is applied. `hash_index[5]` is CRC bit 0. `hash_index[4:0]` holds CRC bits 1..5 reversed, so `hash_index[4]` is CRC bit 1 and `hash_index[0]` is CRC bit 5.
- R3: A group address (bit 0 of byte 0 set) is accepted exactly when bit `hash_index[4:0]` is set in the selected table register. The high register (`cfg_sel`=2) is selected when `hash_index[5]`=1, and the low register (`cfg_sel`=3) otherwise.
- R4: An individual address (bit 0 of byte 0 clear) is accepted exactly when it equals the station address.
  - `cfg_sel`=0 holds bytes 0..3, with byte 0 in bits 31:24.
  - `cfg_sel`=1 holds byte 4 in bits 31:24 and byte 5 in bits 23:16.
  - Bits 15:0 of that write have no effect.
- R5: `decision_valid` is high for exactly one cycle: the cycle after the clock edge that samples the sixth byte. `accept` is 0 whenever `decision_valid` is 0. Idle cycles between bytes are allowed. Bytes after the sixth are ignored until the next `addr_start`.
- R6: With both table registers all ones, every group address is accepted.
- R7: When `promisc_en` is high at the edge that samples the sixth byte, the address is accepted whatever its type, table or station match.
- R8: A byte that arrives with `addr_start` high is always taken as byte 0 of a new address. Any partly received address is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all registers |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 station high, 1 station low, 2 table high, 3 table low |
| cfg_wdata | input | 32 | Register write data |
| promisc_en | input | 1 | Accept every address |
| addr_start | input | 1 | Marks the current byte as byte 0 of an address |
| byte_valid | input | 1 | Address byte present on `byte_data` |
| byte_data | input | 8 | Destination address byte |
| decision_valid | output | 1 | Verdict strobe, one cycle |
| accept | output | 1 | Address accepted (valid with the strobe) |
| hash_index | output | 6 | Last computed hash index: table half in bit 5, bit position in bits 4:0 |

## Verification
The assertions take for granted that `addr_start` is only raised together with `byte_valid`. They also assume that `promisc_en` and the table registers are the values sampled at the sixth-byte edge.

The stimulus keeps to this rule. `addr_start` is driven only on a byte beat. Register writes and mode changes are made on idle cycles, away from the final byte.

The bench still keeps its reference model's ordering of the verdict before the write, so a write landing on the sixth byte would be judged the same way.

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter #(
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
  parameter int          ADDR_LEN = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        promisc_en,
  input  logic        addr_start,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        decision_valid,
  output logic        accept,
  output logic [5:0]  hash_index
);

  localparam int CW = $clog2(ADDR_LEN + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(ADDR_LEN - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(ADDR_LEN);
  localparam int AW = 8 * ADDR_LEN;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  logic [31:0]   crc_q, sta_hi_q, hash_hi_q, hash_lo_q;
  logic [15:0]   sta_lo_q;
  logic [AW-9:0] addr_q;
  logic [CW-1:0] cnt_q;

  wire          mid_addr = (cnt_q != '0) && (cnt_q < FULL_CNT);
  wire          take     = byte_valid & (addr_start | mid_addr);
  wire          last     = byte_valid & ~addr_start & (cnt_q == LAST_CNT);
  wire [31:0]   crc_nx   = crc_byte(addr_start ? 32'hFFFF_FFFF : crc_q, byte_data);
  wire [AW-1:0] full     = {addr_q, byte_data};
  wire [4:0]    bit_sel  = {crc_nx[1], crc_nx[2], crc_nx[3], crc_nx[4], crc_nx[5]};
  wire [31:0]   half     = crc_nx[0] ? hash_hi_q : hash_lo_q;
  wire          grp_hit  = half[bit_sel];
  wire          sta_hit  = full == {sta_hi_q, sta_lo_q};
  wire          is_group = full[AW-8];
  wire          verdict  = promisc_en | (is_group ? grp_hit : sta_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= '1;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (take) begin
      crc_q  <= crc_nx;
      addr_q <= addr_start ? {{(AW-16){1'b0}}, byte_data} : {addr_q[AW-17:0], byte_data};
      cnt_q  <= addr_start ? CW'(1) : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_hi_q  <= '0;
      sta_lo_q  <= '0;
      hash_hi_q <= '0;
      hash_lo_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: sta_hi_q  <= cfg_wdata;
        2'd1: sta_lo_q  <= cfg_wdata[31:16];
        2'd2: hash_hi_q <= cfg_wdata;
        default: hash_lo_q <= cfg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      decision_valid <= 1'b0;
      accept         <= 1'b0;
      hash_index     <= '0;
    end else begin
      decision_valid <= last;
      accept         <= last & verdict;
      if (last) hash_index <= {crc_nx[0], bit_sel};
    end
  end

endmodule

// File: rtl/mcast_addr_filter_chk.sv
module mcast_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        promisc_en,
  input logic        addr_start,
  input logic        byte_valid,
  input logic [7:0]  byte_data,
  input logic        decision_valid,
  input logic        accept,
  input logic [31:0] hash_hi,
  input logic [31:0] hash_lo
);
  logic grp_q;
  always_ff @(posedge clk) begin
    if (!rst_n) grp_q <= 1'b0;
    else if (byte_valid && addr_start) grp_q <= byte_data[0];
  end

  assert_verdict_after_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> $past(byte_valid && !addr_start));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);

  assert_accept_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> !accept);

  assert_promisc_accepts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && $past(promisc_en)) |-> accept);

  assert_full_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && grp_q && $past((&hash_hi) && (&hash_lo))) |-> accept);
endmodule

bind mcast_addr_filter mcast_addr_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .promisc_en(promisc_en), .addr_start(addr_start),
  .byte_valid(byte_valid), .byte_data(byte_data), .decision_valid(decision_valid),
  .accept(accept), .hash_hi(hash_hi_q), .hash_lo(hash_lo_q)
);

// File: tb/mcast_addr_filter_test.sv
`timescale 1ns/1ps
module mcast_addr_filter_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, promisc_en = 0, addr_start = 0, byte_valid = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [7:0] byte_data = 0;
  logic decision_valid, accept;
  logic [5:0] hash_index;

  always #4 clk = ~clk;

  mcast_addr_filter uut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0]  q[$];
  logic [31:0] m_hi = 0, m_lo = 0, m_sta_hi = 0;
  logic [15:0] m_sta_lo = 0;
  logic        e_dv = 0, e_acc = 0;
  logic [5:0]  e_idx = 0;

  function automatic logic [31:0] ref_crc(logic [7:0] b[$]);
    logic [31:0] r = 32'hFFFF_FFFF;
    foreach (b[k])
      for (int j = 0; j < 8; j++) begin
        bit top = r[31];
        r = r << 1;
        if (top != b[k][j]) r = r ^ 32'h04C11DB7;
      end
    return r;
  endfunction

  function automatic logic [5:0] ref_idx(logic [47:0] a);
    logic [7:0] b[$];
    logic [31:0] c;
    logic [5:0] x;
    for (int k = 5; k >= 0; k--) b.push_back(a[8*k +: 8]);
    c = ref_crc(b);
    x[5] = c[0];
    for (int j = 0; j < 5; j++) x[4-j] = c[j+1];
    return x;
  endfunction

  task automatic check(string tag);
    checks++;
    if ({decision_valid, accept, hash_index} !== {e_dv, e_acc, e_idx}) begin
      failures++;
      $display("FAIL %s: dv/acc/idx got %b/%b/%h expected %b/%b/%h", tag,
               decision_valid, accept, hash_index, e_dv, e_acc, e_idx);
    end
  endtask

  task automatic step(string tag, bit bv, bit st, logic [7:0] d,
                      bit we = 0, logic [1:0] sel = 0, logic [31:0] wd = 0);
    byte_valid = bv; addr_start = st; byte_data = d;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    e_dv = 0; e_acc = 0;
    if (bv) begin
      if (st) begin q.delete(); q.push_back(d); end
      else if (q.size() > 0 && q.size() < 6) begin
        q.push_back(d);
        if (q.size() == 6) begin
          logic [47:0] a;
          logic [5:0] x;
          bit hit;
          for (int k = 0; k < 6; k++) a[8*(5-k) +: 8] = q[k];
          x = ref_idx(a);
          if (q[0][0]) hit = x[5] ? m_hi[x[4:0]] : m_lo[x[4:0]];
          else hit = (a == {m_sta_hi, m_sta_lo});
          e_dv = 1; e_idx = x; e_acc = promisc_en | hit;
        end
      end
    end
    if (we) case (sel)
      2'd0: m_sta_hi = wd;
      2'd1: m_sta_lo = wd[31:16];
      2'd2: m_hi = wd;
      default: m_lo = wd;
    endcase
    @(posedge clk); @(negedge clk);
    check(tag);
  endtask

  task automatic send(string tag, logic [47:0] a, int gap = 0);
    for (int k = 0; k < 6; k++) begin
      step(tag, 1, k == 0, a[8*(5-k) +: 8]);
      for (int g = 0; g < gap; g++) step(tag, 0, 0, 0);
    end
    step(tag, 0, 0, 0);
  endtask

  task automatic wr(string tag, logic [1:0] sel, logic [31:0] wd);
    step(tag, 0, 0, 0, 1, sel, wd);
  endtask

  localparam logic [47:0] STA  = 48'h02_1A_2B_3C_4D_5E;
  localparam logic [47:0] GRP1 = 48'h01_00_5E_00_00_FB;
  localparam logic [47:0] GRP2 = 48'h33_33_00_00_00_01;

  initial begin
    logic [5:0] ix;
    repeat (3) @(negedge clk);
    check("R1 reset outputs");
    rst_n = 1;
    step("R1 idle", 0, 0, 0);
    send("R1 cleared table rejects group", GRP1);
    send("R2 broadcast index", 48'hFF_FF_FF_FF_FF_FF);

    wr("R4 station hi", 2'd0, STA[47:16]);
    wr("R4 station lo low bits ignored", 2'd1, {STA[15:0], 16'hA5C3});
    send("R4 station match", STA);
    send("R4 station mismatch", STA ^ 48'h1);
    send("R4 station match with gaps", STA, 2);

    ix = ref_idx(GRP1);
    if (ix[5]) wr("R3 set table bit", 2'd2, 32'h1 << ix[4:0]);
    else       wr("R3 set table bit", 2'd3, 32'h1 << ix[4:0]);
    send("R3 group hit", GRP1);
    if (ix[5]) wr("R3 move to other half", 2'd3, 32'h1 << ix[4:0]);
    else       wr("R3 move to other half", 2'd2, 32'h1 << ix[4:0]);
    if (ix[5]) wr("R3 clear half", 2'd2, 0); else wr("R3 clear half", 2'd3, 0);
    send("R3 other half misses", GRP1);
    send("R3 group miss", GRP2);

    wr("R6 all ones hi", 2'd2, 32'hFFFF_FFFF);
    wr("R6 all ones lo", 2'd3, 32'hFFFF_FFFF);
    send("R6 all group accepted", GRP2);
    send("R6 individual still exact", STA ^ 48'h100);
    wr("R7 clear hi", 2'd2, 0);
    wr("R7 clear lo", 2'd3, 0);

    promisc_en = 1;
    step("R7 idle", 0, 0, 0);
    send("R7 promisc individual", 48'h00_11_22_33_44_55);
    send("R7 promisc group", GRP2);
    promisc_en = 0;
    step("R7 idle", 0, 0, 0);

    step("R8 partial", 1, 1, 8'h01);
    step("R8 partial", 1, 0, 8'h00);
    step("R8 partial", 1, 0, 8'h5E);
    send("R8 restart station", STA);

    send("R5 base", STA);
    step("R5 extra bytes ignored", 1, 0, 8'h77);
    step("R5 extra bytes ignored", 1, 0, 8'h88);
    step("R5 extra bytes ignored", 0, 0, 0);
    step("R5 stray byte without start", 1, 0, 8'h02);
    send("R2 random index", 48'hA1_B2_C3_D4_E5_F7);

    rst_n = 0;
    @(negedge clk);
    q.delete(); m_hi = 0; m_lo = 0; m_sta_hi = 0; m_sta_lo = 0;
    e_dv = 0; e_acc = 0; e_idx = 0;
    check("R1 second reset");
    rst_n = 1;
    send("R1 station cleared", STA);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule